// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block sits on the host side of a group of double-buffered parallel digital-to-analog converters. The converters share one data bus and one write strobe. Each converter has its own input-latch enable, and all of them share one output-latch enable. The host issues commands over a valid/ready handshake. A command can write a data word into the input latch of one chosen converter. It can move every input latch to the outputs at the same instant through the shared output-latch enable. It can also pulse the active-low clear line.

The sequencer produces the bus and control waveforms itself. It drives the enables and data, waits out the setup time, holds the strobe low for the minimum width, and then keeps everything stable through the hold time before it releases the enables. All minimum times are given in nanoseconds and turned into clock-cycle counts when the block is elaborated.

A mode input selects single-buffered operation for the command it accompanies. In that mode a load also opens the output latch, so the converter output follows the new word directly, and every strobe is stretched to the longer width that the pass-through path needs.

Top module: `dac_wr_seq`

## Requirements
- R1: After reset, and whenever the block is idle, every input-latch enable, the output-latch enable, the write strobe and the clear line are high, cmd_ready is high, and after reset the data bus is zero.
- R2: A command is taken at a rising clock edge where cmd_valid and cmd_ready are both high. cmd_ready stays low from the cycle after acceptance until the sequence has finished. A command offered while cmd_ready is low is not taken and has no effect on the outputs.
- R3: A load (cmd_op = 2'b00) drives cmd_data onto the bus and pulls low bit cmd_sel of the input-latch enables, leaving the others high, from the cycle after acceptance. These stay in place for SETUP_CYC cycles before the write strobe falls.
- R4: In double-buffered mode (single_buf = 0) the write strobe stays low for exactly PULSE_CYC cycles.
- R5: After the strobe rises, the enables and the data stay unchanged for HOLD_CYC cycles. In the next cycle the enables are released and cmd_ready is high.
- R6: An update (cmd_op = 2'b01) pulls the output-latch enable low with every input-latch enable high. It leaves the bus at its last value and runs the same setup, strobe and hold sequence.
- R7: With single_buf = 1 at acceptance, a load pulls the output-latch enable low together with the selected input-latch enable. The strobe of any write in this mode stays low for exactly PULSE_SB_CYC cycles.
- R8: A clear (cmd_op = 2'b10) holds the clear line low for exactly CLEAR_CYC cycles, starting in the cycle after acceptance. During that time the enables and the strobe stay high and cmd_ready is low. cmd_ready is high in the cycle after the clear line rises.
- R9: The code cmd_op = 2'b11 is accepted and has no effect. The outputs stay idle and cmd_ready stays high.
- R10: Each cycle count is the time in nanoseconds divided by CLK_NS, rounded up, with a minimum of one cycle.
- R11: At most one input-latch enable is low at any time. The write strobe is low only while some latch enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer can take a command |
| cmd_op | input | 2 | 00 load, 01 update, 10 clear, 11 no-op |
| cmd_sel | input | SEL_W | Converter targeted by a load |
| cmd_data | input | DATA_W | Word for a load |
| single_buf | input | 1 | Single-buffered mode for this command |
| dac_data | output | DATA_W | Shared converter data bus |
| in_en_n | output | NUM_DAC | Per-converter input-latch enables, active low |
| upd_en_n | output | 1 | Shared output-latch enable, active low |
| wr_n | output | 1 | Shared write strobe, active low |
| clr_n | output | 1 | Clear line, active low |

## Verification
Two events can fall in the same clock cycle. When one write releases its enables, the block returns to idle, and in that same idle cycle the next command can already be accepted. The bench keeps a new command waiting at every release, so back-to-back sequences have to show exactly one released cycle between them, with no carry-over of the previous converter's enable. The bench also holds a clear command on the handshake for the whole of each busy write, and judges from the clear line and the enables that the busy sequencer never took it.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_UPD   = 2'b01,
        OP_CLEAR = 2'b10,
        OP_NOP   = 2'b11
    } dac_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_CLEAR
    } seq_state_e;

    // Round a time up to whole clock periods, never less than one.
    function automatic int unsigned ns2cyc(int unsigned t_ns, int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/dac_sel_decode.sv
module dac_sel_decode #(
    parameter int NUM_DAC = 4,
    parameter int SEL_W   = 2
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic               en,
    output logic [NUM_DAC-1:0] onehot_n
);
    for (genvar i = 0; i < NUM_DAC; i++) begin : g_dec
        assign onehot_n[i] = !(en && (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
    import dac_seq_pkg::*;
#(
    parameter int NUM_DAC     = 4,
    parameter int DATA_W      = 16,
    parameter int SEL_W       = (NUM_DAC > 1) ? $clog2(NUM_DAC) : 1,
    parameter int CLK_NS      = 20,
    parameter int SETUP_NS    = 50,
    parameter int HOLD_NS     = 10,
    parameter int PULSE_NS    = 50,
    parameter int PULSE_SB_NS = 80,
    parameter int CLEAR_NS    = 200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_op,
    input  logic [SEL_W-1:0]   cmd_sel,
    input  logic [DATA_W-1:0]  cmd_data,
    input  logic               single_buf,
    output logic [DATA_W-1:0]  dac_data,
    output logic [NUM_DAC-1:0] in_en_n,
    output logic               upd_en_n,
    output logic               wr_n,
    output logic               clr_n
);
    localparam int SETUP_CYC    = ns2cyc(SETUP_NS, CLK_NS);
    localparam int HOLD_CYC     = ns2cyc(HOLD_NS, CLK_NS);
    localparam int PULSE_CYC    = ns2cyc(PULSE_NS, CLK_NS);
    localparam int PULSE_SB_CYC = ns2cyc(PULSE_SB_NS, CLK_NS);
    localparam int CLEAR_CYC    = ns2cyc(CLEAR_NS, CLK_NS);
    localparam int SUM_CYC      = SETUP_CYC + HOLD_CYC + PULSE_CYC + PULSE_SB_CYC + CLEAR_CYC;
    localparam int CNT_W        = $clog2(SUM_CYC + 1);

    typedef struct packed {
        seq_state_e          state;
        logic [DATA_W-1:0]   data;
        logic [NUM_DAC-1:0]  in_en_n;
        logic                upd_en_n;
        logic                wr_n;
        logic                clr_n;
        logic                sb;
    } seq_regs_t;

    seq_regs_t          r_d, r_q;
    logic               t_load;
    logic [CNT_W-1:0]   t_val;
    logic               t_expired;
    logic [NUM_DAC-1:0] sel_n;
    dac_op_e            op;

    assign op = dac_op_e'(cmd_op);

    dac_sel_decode #(
        .NUM_DAC(NUM_DAC),
        .SEL_W  (SEL_W)
    ) i_dec (
        .sel     (cmd_sel),
        .en      (op == OP_LOAD),
        .onehot_n(sel_n)
    );

    dac_phase_timer #(
        .CNT_W(CNT_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .load_val(t_val),
        .expired (t_expired)
    );

    always_comb begin
        r_d    = r_q;
        t_load = 1'b0;
        t_val  = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (op)
                        OP_LOAD, OP_UPD: begin
                            r_d.state    = ST_SETUP;
                            r_d.sb       = single_buf;
                            r_d.in_en_n  = sel_n;
                            r_d.upd_en_n = (op == OP_LOAD) ? !single_buf : 1'b0;
                            if (op == OP_LOAD) begin
                                r_d.data = cmd_data;
                            end
                            t_load = 1'b1;
                            t_val  = CNT_W'(SETUP_CYC - 1);
                        end
                        OP_CLEAR: begin
                            r_d.state = ST_CLEAR;
                            r_d.clr_n = 1'b0;
                            t_load    = 1'b1;
                            t_val     = CNT_W'(CLEAR_CYC - 1);
                        end
                        default: ;
                    endcase
                end
            end
            ST_SETUP: begin
                if (t_expired) begin
                    r_d.state = ST_STROBE;
                    r_d.wr_n  = 1'b0;
                    t_load    = 1'b1;
                    t_val     = r_q.sb ? CNT_W'(PULSE_SB_CYC - 1) : CNT_W'(PULSE_CYC - 1);
                end
            end
            ST_STROBE: begin
                if (t_expired) begin
                    r_d.state = ST_HOLD;
                    r_d.wr_n  = 1'b1;
                    t_load    = 1'b1;
                    t_val     = CNT_W'(HOLD_CYC - 1);
                end
            end
            ST_HOLD: begin
                if (t_expired) begin
                    r_d.state    = ST_IDLE;
                    r_d.in_en_n  = '1;
                    r_d.upd_en_n = 1'b1;
                end
            end
            ST_CLEAR: begin
                if (t_expired) begin
                    r_d.state = ST_IDLE;
                    r_d.clr_n = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.data     <= '0;
            r_q.in_en_n  <= '1;
            r_q.upd_en_n <= 1'b1;
            r_q.wr_n     <= 1'b1;
            r_q.clr_n    <= 1'b1;
            r_q.sb       <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = (r_q.state == ST_IDLE);
    assign dac_data  = r_q.data;
    assign in_en_n   = r_q.in_en_n;
    assign upd_en_n  = r_q.upd_en_n;
    assign wr_n      = r_q.wr_n;
    assign clr_n     = r_q.clr_n;
endmodule

module dac_wr_seq_chk #(
    parameter int NUM_DAC = 4,
    parameter int DATA_W  = 16,
    parameter int MIN_LOW = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_ready,
    input logic [DATA_W-1:0]  dac_data,
    input logic [NUM_DAC-1:0] in_en_n,
    input logic               upd_en_n,
    input logic               wr_n,
    input logic               clr_n
);
    logic [7:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (!wr_n) begin
            low_cnt_q <= (low_cnt_q == 8'hFF) ? low_cnt_q : low_cnt_q + 1'b1;
        end else begin
            low_cnt_q <= '0;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (wr_n && clr_n && upd_en_n && (&in_en_n)));

    // R2
    busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !cmd_ready);

    // R3
    setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ($stable(in_en_n) && $stable(upd_en_n) && $stable(dac_data)));

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (low_cnt_q >= 8'(MIN_LOW)));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> ($stable(in_en_n) && $stable(upd_en_n) && $stable(dac_data)));

    // R8
    clear_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (wr_n && upd_en_n && (&in_en_n) && !cmd_ready));

    // R11
    one_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~in_en_n));

    // R11
    strobe_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (!upd_en_n || !(&in_en_n)));
endmodule

bind dac_wr_seq dac_wr_seq_chk #(
    .NUM_DAC(NUM_DAC),
    .DATA_W (DATA_W),
    .MIN_LOW(PULSE_CYC)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_ready(cmd_ready),
    .dac_data (dac_data),
    .in_en_n  (in_en_n),
    .upd_en_n (upd_en_n),
    .wr_n     (wr_n),
    .clr_n    (clr_n)
);

// File: tb/test_dac_wr_seq.sv
module test_dac_wr_seq;
    localparam int NUM_DAC  = 4;
    localparam int DATA_W   = 16;
    localparam int SEL_W    = 2;
    localparam int CLK_NS   = 20;
    // R10: bench-side ceilings of 50, 10, 50, 80 and 200 ns at 20 ns
    localparam int E_SETUP  = (50 + CLK_NS - 1) / CLK_NS;
    localparam int E_HOLD   = (10 + CLK_NS - 1) / CLK_NS;
    localparam int E_PULSE  = (50 + CLK_NS - 1) / CLK_NS;
    localparam int E_PSB    = (80 + CLK_NS - 1) / CLK_NS;
    localparam int E_CLEAR  = (200 + CLK_NS - 1) / CLK_NS;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_valid = 1'b0;
    logic               cmd_ready;
    logic [1:0]         cmd_op = 2'b11;
    logic [SEL_W-1:0]   cmd_sel = '0;
    logic [DATA_W-1:0]  cmd_data = '0;
    logic               single_buf = 1'b0;
    logic [DATA_W-1:0]  dac_data;
    logic [NUM_DAC-1:0] in_en_n;
    logic               upd_en_n;
    logic               wr_n;
    logic               clr_n;

    int tests = 0;
    int fails = 0;
    logic [DATA_W-1:0] last_data = '0;

    always #10 clk = ~clk;

    dac_wr_seq #(
        .NUM_DAC    (NUM_DAC),
        .DATA_W     (DATA_W),
        .SEL_W      (SEL_W),
        .CLK_NS     (CLK_NS),
        .SETUP_NS   (50),
        .HOLD_NS    (10),
        .PULSE_NS   (50),
        .PULSE_SB_NS(80),
        .CLEAR_NS   (200)
    ) i_dac_wr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_sel   (cmd_sel),
        .cmd_data  (cmd_data),
        .single_buf(single_buf),
        .dac_data  (dac_data),
        .in_en_n   (in_en_n),
        .upd_en_n  (upd_en_n),
        .wr_n      (wr_n),
        .clr_n     (clr_n)
    );

    task automatic check(string req, logic [DATA_W-1:0] e_data, logic [NUM_DAC-1:0] e_in,
                         logic e_upd, logic e_wr, logic e_clr, logic e_rdy);
        tests++;
        if ({dac_data, in_en_n, upd_en_n, wr_n, clr_n, cmd_ready} !==
            {e_data, e_in, e_upd, e_wr, e_clr, e_rdy}) begin
            fails++;
            $display("FAIL %s t=%0t data/in/upd/wr/clr/rdy actual %h/%b/%b/%b/%b/%b expected %h/%b/%b/%b/%b/%b",
                     req, $time, dac_data, in_en_n, upd_en_n, wr_n, clr_n, cmd_ready,
                     e_data, e_in, e_upd, e_wr, e_clr, e_rdy);
        end
    endtask

    // Called just after a falling edge; returns just after a falling edge.
    task automatic run_cmd(logic [1:0] op, int sel, logic [DATA_W-1:0] data, logic sb, logic nag);
        int wx;
        int tot;
        logic [DATA_W-1:0] ed;
        wx = sb ? E_PSB : E_PULSE;
        if (op == 2'b10)      tot = E_CLEAR + 1;
        else if (op == 2'b11) tot = 1;
        else                  tot = E_SETUP + wx + E_HOLD + 1;
        ed = (op == 2'b00) ? data : last_data;
        cmd_op     = op;
        cmd_sel    = SEL_W'(sel);
        cmd_data   = data;
        single_buf = sb;
        cmd_valid  = 1'b1;
        // R2: ready before acceptance
        check("R2", last_data, '1, 1'b1, 1'b1, 1'b1, 1'b1);
        for (int t = 1; t <= tot; t++) begin
            @(negedge clk);
            if (t == 1) begin
                cmd_valid = nag;
                cmd_op    = 2'b10;
                cmd_data  = ~data;
            end
            if (op == 2'b10) begin
                check("R8", last_data, '1, 1'b1, 1'b1, (t > E_CLEAR), (t == tot));
            end else if (op == 2'b11) begin
                check("R9", last_data, '1, 1'b1, 1'b1, 1'b1, 1'b1);
            end else begin
                logic act;
                logic [NUM_DAC-1:0] e_in;
                logic e_upd;
                string rq;
                act   = (t < tot);
                e_in  = (act && op == 2'b00) ? ~(NUM_DAC'(1) << sel) : '1;
                e_upd = !(act && (op == 2'b01 || sb));
                if (nag && t < tot)           rq = "R2 busy";
                else if (op == 2'b01)         rq = "R6";
                else if (t <= E_SETUP)        rq = "R3";
                else if (t <= E_SETUP + wx)   rq = sb ? "R7 R10" : "R4 R10";
                else                          rq = "R5 R11";
                check(rq, ed, e_in, e_upd, !(t > E_SETUP && t <= E_SETUP + wx), 1'b1, (t == tot));
            end
            if (t == tot) cmd_valid = 1'b0;
        end
        last_data = ed;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", '0, '1, 1'b1, 1'b1, 1'b1, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", '0, '1, 1'b1, 1'b1, 1'b1, 1'b1);
        // R3 R4 R5 R7: loads to every converter, both modes, several words
        for (int sb = 0; sb < 2; sb++) begin
            for (int s = 0; s < NUM_DAC; s++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [DATA_W-1:0] w;
                    w = (p == 0) ? 16'h7FFF : (p == 1) ? 16'h8000 :
                        (p == 2) ? 16'h0000 : 16'hFFFF ^ DATA_W'(s * 16'h1111);
                    run_cmd(2'b00, s, w, sb[0], 1'b0);
                end
            end
            // R6: shared update keeps the bus
            run_cmd(2'b01, 0, 16'h1234, sb[0], 1'b0);
        end
        // R8: clear between writes
        run_cmd(2'b10, 0, 16'h0F0F, 1'b0, 1'b0);
        run_cmd(2'b00, 2, 16'h4000, 1'b0, 1'b0);
        // R9: reserved code
        run_cmd(2'b11, 1, 16'hAAAA, 1'b0, 1'b0);
        // R2: clear offered during busy writes is not taken
        run_cmd(2'b00, 3, 16'hC000, 1'b0, 1'b1);
        run_cmd(2'b01, 0, 16'h0001, 1'b1, 1'b1);
        run_cmd(2'b00, 1, 16'h0001, 1'b1, 1'b1);
        // R1: idle after all
        @(negedge clk);
        check("R1", last_data, '1, 1'b1, 1'b1, 1'b1, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule